// File: doc/BRIEF.md
# Fabric frame receive buffer

This block takes a byte stream of switch-fabric frames and places the payload of selected frame types into a small pool of buffer elements. A frame opens with a byte flagged as start of frame, whose low four bits give the frame type. The next byte gives the payload length in bytes, and that many payload bytes follow. A per-type enable mask chooses which types are kept. A kept frame claims a free element on its start byte. The element closes when exactly the announced number of payload bytes has arrived. If a new start of frame cuts the frame short, the element closes early with an error flag.

Each closed element produces a 64-bit status record. The record is sent to the consumer as two 32-bit words on consecutive cycles, low half first. The consumer reads the payload through a byte read port. It hands the element back by writing the element index on the release input. Frames of disabled types, and frames that find no free element, are swallowed up to the next start of frame.

Top module: `fab_rx_buffer`

## Requirements
- R1: A buffer element is claimed only by a byte with in_valid and in_sof high whose low four bits (the type) select a set bit in type_map; the lowest-numbered free element is taken.
- R2: A frame whose type bit in type_map is clear is discarded up to the next start of frame: it produces no status and claims no element.
- R3: Payload byte n of a kept frame (n counted from 0, after the type byte and the length byte) is readable at rd_addr n of its element through rd_elem/rd_addr/rd_data.
- R4: An element closes with error clear once the number of payload bytes given by the length byte has arrived; a length of 0 closes it on the length byte itself.
- R5: A start of frame that arrives while an element is still open (waiting for its length byte or its payload) closes that element with the error bit set and the count of payload bytes received so far, and the same byte starts the next frame.
- R6: Status low word: bits 15:0 byte count, bits 23:16 type, bit 31 error, other bits zero; high word: bits 7:0 element index, other bits zero. The low word is on stat_word (stat_valid high, stat_hi low) in the cycle after the clock edge that closed the element, the high word (stat_hi high) in the cycle after that; a record queued behind another starts in the cycle after the previous high word.
- R7: A write with done_valid high returns element done_idx to the free pool; a kept frame that finds no free element is discarded with no status.
- R8: After reset no status word is presented and every element is free.
- R9: Bytes with in_valid low, and bytes without the start flag that arrive while no frame is in progress, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | The present byte starts a frame and carries the type |
| in_data | input | 8 | Frame byte |
| type_map | input | 16 | One enable bit per frame type |
| done_valid | input | 1 | Release strobe |
| done_idx | input | 2 | Element to release |
| rd_elem | input | 2 | Element to read |
| rd_addr | input | 8 | Byte offset to read |
| rd_data | output | 8 | Stored byte at rd_elem/rd_addr |
| stat_valid | output | 1 | A status word is presented |
| stat_hi | output | 1 | The presented word is the upper half |
| stat_word | output | 32 | Status word |

## Verification
A record's low word is due one cycle after the edge that takes in the closing byte: the last payload byte, a zero length byte, or the interrupting start byte. Its high word is due one cycle later. A record queued behind another starts only after the previous high word. The bench notes the edge number at which each closing byte is taken, and a monitor stamps each low word with the edge count at the following falling edge. Each check then compares the stamp with the due cycle worked out from those rules, including the queued case after an early close.

// File: rtl/fab_rx_pkg.sv
package fab_rx_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_LEN  = 2'd1,
      PS_PAY  = 2'd2,
      PS_DROP = 2'd3
   } prs_state_e;

   // completion record handed from the parser to the status queue
   typedef struct packed {
      logic        err;
      logic [7:0]  idx;
      logic [7:0]  ftype;
      logic [15:0] count;
   } cmpl_t;

   function automatic logic [63:0] pack_status(input cmpl_t c);
      logic [31:0] lo;
      logic [31:0] hi;
      lo = {c.err, 7'd0, c.ftype, c.count};
      hi = {24'd0, c.idx};
      return {hi, lo};
   endfunction

endpackage

// File: rtl/fab_rx_parser.sv
module fab_rx_parser
   import fab_rx_pkg::*;
#(
   parameter int NUM_ELEM = 4,
   parameter int LEN_W    = 8,
   parameter int TYPE_W   = 4,
   localparam int IDX_W     = $clog2(NUM_ELEM),
   localparam int NUM_TYPES = 1 << TYPE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic [7:0]           in_data,
   input  logic [NUM_TYPES-1:0] type_map,
   input  logic                 pool_avail,
   input  logic [IDX_W-1:0]     pool_idx,
   output logic                 alloc_en,
   output logic                 wr_en,
   output logic [IDX_W-1:0]     wr_elem,
   output logic [LEN_W-1:0]     wr_addr,
   output logic [7:0]           wr_data,
   output logic                 push_en,
   output cmpl_t                push_rec
);

   prs_state_e        state_q;
   logic [IDX_W-1:0]  cur_q;
   logic [TYPE_W-1:0] type_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;

   logic              is_sof;
   logic              is_dat;
   logic [TYPE_W-1:0] frame_type;
   logic              mapped;
   logic              elem_open;
   logic              early_close;
   logic              last_byte;
   logic              zero_close;
   logic [LEN_W-1:0]  len_byte;
   logic [LEN_W-1:0]  cnt_sel;

   always_comb begin
      is_sof      = in_valid & in_sof;
      is_dat      = in_valid & ~in_sof;
      frame_type  = in_data[TYPE_W-1:0];
      mapped      = type_map[frame_type];
      len_byte    = in_data[LEN_W-1:0];
      elem_open   = (state_q == PS_LEN) || (state_q == PS_PAY);
      early_close = is_sof && elem_open;
      last_byte   = (state_q == PS_PAY) && is_dat &&
                    (({1'b0, cnt_q} + (LEN_W+1)'(1)) == {1'b0, len_q});
      zero_close  = (state_q == PS_LEN) && is_dat && (len_byte == '0);
   end

   always_comb begin
      if (last_byte)               cnt_sel = len_q;
      else if (state_q == PS_PAY)  cnt_sel = cnt_q;
      else                         cnt_sel = '0;
   end

   always_comb begin
      alloc_en       = is_sof && mapped && pool_avail;
      wr_en          = (state_q == PS_PAY) && is_dat;
      wr_elem        = cur_q;
      wr_addr        = cnt_q;
      wr_data        = in_data;
      push_en        = early_close || last_byte || zero_close;
      push_rec.err   = early_close;
      push_rec.idx   = 8'(cur_q);
      push_rec.ftype = 8'(type_q);
      push_rec.count = 16'(cnt_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         cur_q   <= '0;
         type_q  <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
      end else if (is_sof) begin
         state_q <= (mapped && pool_avail) ? PS_LEN : PS_DROP;
         cur_q   <= pool_idx;
         type_q  <= frame_type;
         cnt_q   <= '0;
      end else if (is_dat) begin
         case (state_q)
            PS_LEN: begin
               len_q   <= len_byte;
               cnt_q   <= '0;
               state_q <= zero_close ? PS_IDLE : PS_PAY;
            end
            PS_PAY: begin
               cnt_q <= cnt_q + LEN_W'(1);
               if (last_byte) state_q <= PS_IDLE;
            end
            default: state_q <= state_q;
         endcase
      end
   end

endmodule

// File: rtl/fab_rx_pool.sv
module fab_rx_pool #(
   parameter int NUM_ELEM    = 4,
   parameter int ALLOC_ORDER = 0,
   localparam int IDX_W = $clog2(NUM_ELEM)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_en,
   input  logic                done_en,
   input  logic [IDX_W-1:0]    done_idx,
   output logic                avail,
   output logic [IDX_W-1:0]    pick_idx,
   output logic [NUM_ELEM-1:0] free_mask
);

   logic [NUM_ELEM-1:0] free_q;
   logic [NUM_ELEM-1:0] free_d;
   logic                done_ok;

   assign free_mask = free_q;
   assign avail     = |free_q;
   assign done_ok   = done_en && (int'(done_idx) < NUM_ELEM);

   generate
      if (ALLOC_ORDER == 0) begin : g_lowest
         always_comb begin
            logic found;
            found    = 1'b0;
            pick_idx = '0;
            for (int i = 0; i < NUM_ELEM; i++) begin
               if (!found && free_q[i]) begin
                  pick_idx = IDX_W'(i);
                  found    = 1'b1;
               end
            end
         end
      end else begin : g_rotate
         logic [IDX_W-1:0] last_q;
         always_comb begin
            logic found;
            int   j;
            found    = 1'b0;
            pick_idx = '0;
            for (int i = 0; i < NUM_ELEM; i++) begin
               j = (int'(last_q) + 1 + i) % NUM_ELEM;
               if (!found && free_q[j]) begin
                  pick_idx = IDX_W'(j);
                  found    = 1'b1;
               end
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        last_q <= IDX_W'(NUM_ELEM - 1);
            else if (alloc_en) last_q <= pick_idx;
         end
      end
   endgenerate

   always_comb begin
      free_d = free_q;
      if (alloc_en) free_d[pick_idx] = 1'b0;
      if (done_ok)  free_d[done_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= '1;
      else        free_q <= free_d;
   end

endmodule

// File: rtl/fab_rx_store.sv
module fab_rx_store #(
   parameter int NUM_ELEM = 4,
   parameter int LEN_W    = 8,
   parameter int RD_REG   = 0,
   localparam int IDX_W = $clog2(NUM_ELEM),
   localparam int DEPTH = 1 << LEN_W
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_elem,
   input  logic [LEN_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_elem,
   input  logic [LEN_W-1:0] rd_addr,
   output logic [7:0]       rd_data
);

   logic [7:0] bank_rd [NUM_ELEM];
   logic [7:0] rd_sel;

   generate
      for (genvar g = 0; g < NUM_ELEM; g++) begin : g_bank
         logic [7:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && (wr_elem == IDX_W'(g))) mem[wr_addr] <= wr_data;
         end
         assign bank_rd[g] = mem[rd_addr];
      end
   endgenerate

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NUM_ELEM; i++) begin
         if (rd_elem == IDX_W'(i)) rd_sel = bank_rd[i];
      end
   end

   generate
      if (RD_REG == 0) begin : g_rd_comb
         assign rd_data = rd_sel;
      end else begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) rd_q <= rd_sel;
         assign rd_data = rd_q;
      end
   endgenerate

endmodule

// File: rtl/fab_rx_statq.sv
module fab_rx_statq
   import fab_rx_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push_en,
   input  cmpl_t       push_rec,
   output logic        stat_valid,
   output logic        stat_hi,
   output logic [31:0] stat_word
);

   cmpl_t       q_mem [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic [CW-1:0] fill;
   logic          phase_q;
   logic          pop;
   logic          empty;
   logic [63:0]   head_words;

   function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   assign pop        = phase_q;
   assign empty      = (fill == '0);
   assign head_words = pack_status(q_mem[rd_ptr]);

   always_ff @(posedge clk) begin
      if (push_en) q_mem[wr_ptr] <= push_rec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_en) wr_ptr <= ptr_next(wr_ptr);
         if (pop)     rd_ptr <= ptr_next(rd_ptr);
         case ({push_en, pop})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= 1'b0;
         stat_valid <= 1'b0;
         stat_hi    <= 1'b0;
         stat_word  <= '0;
      end else if (phase_q) begin
         stat_word  <= head_words[63:32];
         stat_valid <= 1'b1;
         stat_hi    <= 1'b1;
         phase_q    <= 1'b0;
      end else if (!empty) begin
         stat_word  <= head_words[31:0];
         stat_valid <= 1'b1;
         stat_hi    <= 1'b0;
         phase_q    <= 1'b1;
      end else begin
         stat_valid <= 1'b0;
         stat_hi    <= 1'b0;
      end
   end

endmodule

// File: rtl/fab_rx_buffer.sv
module fab_rx_buffer
   import fab_rx_pkg::*;
#(
   parameter int NUM_ELEM    = 4,
   parameter int LEN_W       = 8,
   parameter int TYPE_W      = 4,
   parameter int ALLOC_ORDER = 0,
   parameter int RD_REG      = 0,
   localparam int IDX_W     = $clog2(NUM_ELEM),
   localparam int NUM_TYPES = 1 << TYPE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic [7:0]           in_data,
   input  logic [NUM_TYPES-1:0] type_map,
   input  logic                 done_valid,
   input  logic [IDX_W-1:0]     done_idx,
   input  logic [IDX_W-1:0]     rd_elem,
   input  logic [LEN_W-1:0]     rd_addr,
   output logic [7:0]           rd_data,
   output logic                 stat_valid,
   output logic                 stat_hi,
   output logic [31:0]          stat_word
);

   initial begin : p_param_check
      assert (NUM_ELEM >= 2 && NUM_ELEM <= 256)
         else $fatal(1, "NUM_ELEM must lie in 2..256");
      assert (LEN_W >= 1 && LEN_W <= 8)
         else $fatal(1, "LEN_W must lie in 1..8");
      assert (TYPE_W >= 1 && TYPE_W <= 8)
         else $fatal(1, "TYPE_W must lie in 1..8");
      assert (ALLOC_ORDER == 0 || ALLOC_ORDER == 1)
         else $fatal(1, "ALLOC_ORDER must be 0 or 1");
      assert (RD_REG == 0 || RD_REG == 1)
         else $fatal(1, "RD_REG must be 0 or 1");
   end

   logic                alloc_en;
   logic                pool_avail;
   logic [IDX_W-1:0]    pool_idx;
   logic [NUM_ELEM-1:0] free_mask;
   logic                wr_en;
   logic [IDX_W-1:0]    wr_elem;
   logic [LEN_W-1:0]    wr_addr;
   logic [7:0]          wr_data;
   logic                push_en;
   cmpl_t               push_rec;
   logic                push_err;

   assign push_err = push_rec.err;

   fab_rx_parser #(
      .NUM_ELEM (NUM_ELEM),
      .LEN_W    (LEN_W),
      .TYPE_W   (TYPE_W)
   ) u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sof     (in_sof),
      .in_data    (in_data),
      .type_map   (type_map),
      .pool_avail (pool_avail),
      .pool_idx   (pool_idx),
      .alloc_en   (alloc_en),
      .wr_en      (wr_en),
      .wr_elem    (wr_elem),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .push_en    (push_en),
      .push_rec   (push_rec)
   );

   fab_rx_pool #(
      .NUM_ELEM    (NUM_ELEM),
      .ALLOC_ORDER (ALLOC_ORDER)
   ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_en),
      .done_en   (done_valid),
      .done_idx  (done_idx),
      .avail     (pool_avail),
      .pick_idx  (pool_idx),
      .free_mask (free_mask)
   );

   fab_rx_store #(
      .NUM_ELEM (NUM_ELEM),
      .LEN_W    (LEN_W),
      .RD_REG   (RD_REG)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_elem (wr_elem),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_elem (rd_elem),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   fab_rx_statq #(
      .DEPTH (NUM_ELEM)
   ) u_statq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_en    (push_en),
      .push_rec   (push_rec),
      .stat_valid (stat_valid),
      .stat_hi    (stat_hi),
      .stat_word  (stat_word)
   );

endmodule

// File: rtl/fab_rx_buffer_chk.sv
module fab_rx_buffer_chk #(
   parameter int NUM_ELEM = 4,
   localparam int IDX_W = $clog2(NUM_ELEM)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_sof,
   input logic                alloc_en,
   input logic [IDX_W-1:0]    alloc_idx,
   input logic [NUM_ELEM-1:0] free_mask,
   input logic                push_en,
   input logic                push_err,
   input logic                stat_valid,
   input logic                stat_hi,
   input logic [31:0]         stat_word
);

   assert_alloc_from_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> free_mask[alloc_idx]);

   assert_alloc_at_sof_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (in_valid && in_sof));

   assert_error_only_at_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && push_err) |-> (in_valid && in_sof));

   assert_hi_after_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && !stat_hi) |=> (stat_valid && stat_hi));

   assert_lo_before_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_hi) |-> $past(stat_valid && !stat_hi));

   assert_hi_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_hi) |-> (stat_word < 32'(NUM_ELEM)));

   assert_hi_flag_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hi |-> stat_valid);

endmodule

bind fab_rx_buffer fab_rx_buffer_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sof     (in_sof),
   .alloc_en   (alloc_en),
   .alloc_idx  (pool_idx),
   .free_mask  (free_mask),
   .push_en    (push_en),
   .push_err   (push_err),
   .stat_valid (stat_valid),
   .stat_hi    (stat_hi),
   .stat_word  (stat_word)
);

// File: tb/sim_fab_rx_buffer.sv
`timescale 1ns/1ps
module sim_fab_rx_buffer;

   localparam int CLK_PERIOD = 10;
   localparam int NE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [7:0]  in_data = '0;
   logic [15:0] type_map = 16'h000B;
   logic        done_valid = 1'b0;
   logic [1:0]  done_idx = '0;
   logic [1:0]  rd_elem = '0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        stat_valid;
   logic        stat_hi;
   logic [31:0] stat_word;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int last_edge = 0;
   bit finished = 0;

   logic [31:0] lo_w [64];
   logic [31:0] hi_w [64];
   int          lo_cyc [64];
   int          n_lo = 0;
   int          n_hi = 0;
   int          n_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fab_rx_buffer u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sof     (in_sof),
      .in_data    (in_data),
      .type_map   (type_map),
      .done_valid (done_valid),
      .done_idx   (done_idx),
      .rd_elem    (rd_elem),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .stat_valid (stat_valid),
      .stat_hi    (stat_hi),
      .stat_word  (stat_word)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && stat_valid) begin
         if (!stat_hi) begin
            if (n_lo < 64) begin
               lo_w[n_lo]   = stat_word;
               lo_cyc[n_lo] = cyc;
            end
            n_lo++;
         end else begin
            if (n_hi < 64) hi_w[n_hi] = stat_word;
            n_hi++;
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic send_byte(input bit sof, input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = sof;
      in_data  = d;
      @(posedge clk);
      #1 last_edge = cyc;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_data  = '0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   task automatic send_frame(input logic [3:0] ftype, input logic [7:0] len,
                             input int nbytes, input logic [7:0] base);
      send_byte(1'b1, {4'hA, ftype});
      send_byte(1'b0, len);
      for (int i = 0; i < nbytes; i++) send_byte(1'b0, base + 8'(i));
   endtask

   task automatic release_elem(input logic [1:0] idx);
      @(negedge clk);
      done_valid = 1'b1;
      done_idx   = idx;
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic expect_stat(input string tag, input int idx, input int ftype,
                              input int cnt, input bit err, input int due);
      int waited;
      waited = 0;
      while (n_hi <= n_seen && waited < 40) begin
         @(negedge clk);
         waited++;
      end
      if (n_hi <= n_seen) begin
         chk(tag, "status record present", 32'd0, 32'd1);
      end else begin
         chk(tag, "low word", lo_w[n_seen],
             {err, 7'd0, 8'(ftype), 16'(cnt)});
         chk(tag, "high word", hi_w[n_seen], 32'(idx));
         chk(tag, "low word cycle", 32'(lo_cyc[n_seen]), 32'(due));
      end
      n_seen++;
   endtask

   task automatic expect_no_stat(input string tag);
      for (int i = 0; i < 8; i++) @(negedge clk);
      chk(tag, "no status words", 32'(n_lo), 32'(n_seen));
   endtask

   task automatic check_byte(input string tag, input logic [1:0] e,
                             input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      rd_elem = e;
      rd_addr = a;
      #1 chk(tag, "stored byte", 32'(rd_data), 32'(exp));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R8", "stat_valid after reset", 32'(stat_valid), 32'd0);
      chk("R8", "stat_hi after reset", 32'(stat_hi), 32'd0);
   endtask

   task automatic t_basic;
      send_frame(4'd3, 8'd4, 4, 8'hA0);
      idle(1);
      expect_stat("R4", 0, 3, 4, 1'b0, last_edge + 1);
      for (int i = 0; i < 4; i++)
         check_byte("R3", 2'd0, 8'(i), 8'hA0 + 8'(i));
      release_elem(2'd0);
   endtask

   task automatic t_unmapped;
      send_frame(4'd5, 8'd2, 2, 8'h30);
      idle(1);
      expect_no_stat("R2");
      send_frame(4'd1, 8'd1, 1, 8'h55);
      idle(1);
      expect_stat("R2", 0, 1, 1, 1'b0, last_edge + 1);
      check_byte("R3", 2'd0, 8'd0, 8'h55);
      release_elem(2'd0);
   endtask

   task automatic t_zero_len;
      send_frame(4'd3, 8'd0, 0, 8'h00);
      idle(1);
      expect_stat("R4", 0, 3, 0, 1'b0, last_edge + 1);
      release_elem(2'd0);
   endtask

   task automatic t_premature;
      int k;
      int m;
      send_frame(4'd3, 8'd6, 2, 8'hC0);
      send_byte(1'b1, 8'h03);
      k = last_edge;
      send_byte(1'b0, 8'd1);
      send_byte(1'b0, 8'h77);
      send_byte(1'b1, 8'h01);
      send_byte(1'b1, 8'h03);
      m = last_edge;
      send_byte(1'b0, 8'd0);
      idle(1);
      expect_stat("R5", 0, 3, 2, 1'b1, k + 1);
      expect_stat("R5", 1, 3, 1, 1'b0, k + 3);
      expect_stat("R5", 2, 1, 0, 1'b1, m + 1);
      expect_stat("R6", 3, 3, 0, 1'b0, m + 3);
      check_byte("R5", 2'd0, 8'd1, 8'hC1);
      check_byte("R5", 2'd1, 8'd0, 8'h77);
      for (int i = 0; i < NE; i++) release_elem(2'(i));
   endtask

   task automatic t_full_pool;
      for (int i = 0; i < NE; i++) begin
         send_frame(4'd0, 8'd1, 1, 8'h10 + 8'(i));
         idle(1);
         expect_stat("R1", i, 0, 1, 1'b0, last_edge + 1);
      end
      send_frame(4'd3, 8'd2, 2, 8'hE0);
      idle(1);
      expect_no_stat("R7");
      release_elem(2'd2);
      send_frame(4'd3, 8'd1, 1, 8'h99);
      idle(1);
      expect_stat("R7", 2, 3, 1, 1'b0, last_edge + 1);
      check_byte("R7", 2'd2, 8'd0, 8'h99);
      check_byte("R7", 2'd3, 8'd0, 8'h13);
      for (int i = 0; i < NE; i++) release_elem(2'(i));
   endtask

   task automatic t_ignored;
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b1;
      in_data  = 8'h03;
      for (int i = 0; i < 3; i++) @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_data  = 8'h02;
      @(negedge clk);
      in_data  = 8'h44;
      idle(1);
      expect_no_stat("R9");
      send_frame(4'd3, 8'd1, 1, 8'h5A);
      idle(1);
      expect_stat("R9", 0, 3, 1, 1'b0, last_edge + 1);
      release_elem(2'd0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_unmapped();
      t_zero_len();
      t_premature();
      t_full_pool();
      t_ignored();
      idle(4);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule